// File: doc/BRIEF.md
# Width-Converting Single-Clock FIFO

This block is a first-in, first-out queue on one clock whose write port and read port carry different data widths. The wider port's width is the narrower one multiplied by 1, 2, 4 or 8, in either direction. It can split each wide word into several narrow reads, or it can gather several narrow writes into one wide read. Internally the queue holds data in slices of the narrower width, and the depth parameter counts those slices.

Lane order is fixed and most-significant first on both sides. A wide word leaves as its top slice first. When narrow words are packed, the first one written fills the top slice of the read word. Both flags describe whole words on their own side. `empty` is raised while less than one complete read word is stored. `full` is raised while there is no room for one complete write word. Read data passes through a register, and `rd_valid` marks the cycle in which a read word appears.

Top module: `asym_width_fifo`

## Requirements
- R1: The parameters WR_W and RD_W may differ by a factor of 1, 2, 4 or 8 in either direction, and the queue stores data in slices of min(WR_W, RD_W) bits.
- R2: When WR_W is wider, each written word is returned as WR_W/RD_W reads in this order: bits [WR_W-1 -: RD_W] first, then each next lower slice, with bits [RD_W-1:0] last.
- R3: When RD_W is wider, RD_W/WR_W consecutive accepted writes form one read word. The first write occupies bits [RD_W-1 -: WR_W], and the last write occupies bits [WR_W-1:0].
- R4: `empty` is 1 exactly when fewer than RD_W/min(WR_W,RD_W) slices are stored. After one wide write it clears, and it sets again only after the last slice of that word has been read. With narrow writes it stays at 1 until enough slices for a full read word are present.
- R5: `full` is 1 exactly when fewer than WR_W/min(WR_W,RD_W) free slices remain. An accepted write always stores a complete write word.
- R6: A read requested while `empty` is 1 is ignored. `rd_valid` stays 0 in the next cycle, and the later data order is unchanged.
- R7: A write requested while `full` is 1 is ignored. The stored data and its order are not changed.
- R8: An accepted read shows its word on `rd_data` with `rd_valid` = 1 in the next cycle. `rd_valid` is 0 in every other cycle.
- R9: While `rst_n` is low at a clock edge, the queue empties. After that edge `empty` = 1, `full` = 0, `rd_valid` = 0 and `rd_data` = 0.
- R10: If a write and a read are both accepted in the same cycle, both take effect, and the stored amount changes by the write slices minus the read slices.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for every register |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write request |
| wr_data | input | WR_W | Word to write |
| full | output | 1 | No room for a complete write word |
| rd_en | input | 1 | Read request |
| rd_data | output | RD_W | Registered read word |
| empty | output | 1 | Less than one complete read word stored |
| rd_valid | output | 1 | `rd_data` holds the word of the previous accepted read |

## Verification
The assertions are checked on every cycle. They cover that an empty queue stays empty without a write and a full queue stays full without a read, that `rd_valid` follows an accepted read and never follows a refused one, and that the stored count never exceeds the depth. Lane ordering in both directions can only be shown by the bench's scenarios, which compare data against a slice-level reference queue. The same holds for the exact points where the flags switch at partial-word fill levels and for data staying intact after refused operations. The bench drives two instances, one splitting 32-bit writes into 8-bit reads and one packing 8-bit writes into 32-bit reads.

// File: rtl/asym_fifo_pkg.sv
// Package: width arithmetic shared by the width-converting FIFO.
// Assumes both widths are positive and that one divides the other.
package asym_fifo_pkg;

    // Slice width: the narrower of the two port widths.
    function automatic int slice_width(input int wr_w, input int rd_w);
        return (wr_w < rd_w) ? wr_w : rd_w;
    endfunction

    // Number of slices making up one word of the given width.
    function automatic int slices_per(input int port_w, input int wr_w, input int rd_w);
        return port_w / slice_width(wr_w, rd_w);
    endfunction

endpackage

// File: rtl/asym_fifo_ctrl.sv
// Occupancy control: tracks the stored slice count and both pointers.
// Accepts a write only when a whole write word fits, and a read only
// when a whole read word is present. Assumes DEPTH is a power of two
// and a multiple of both WR_UNITS and RD_UNITS.
module asym_fifo_ctrl #(
    parameter int DEPTH    = 32,
    parameter int WR_UNITS = 4,
    parameter int RD_UNITS = 1,
    localparam int AW      = $clog2(DEPTH),
    localparam int CW      = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    output logic          full,
    output logic          empty,
    output logic          wr_go,
    output logic          rd_go,
    output logic [AW-1:0] wptr,
    output logic [AW-1:0] rptr
);

    logic [CW-1:0] level;
    logic [CW-1:0] level_nxt;

    // Flags in whole words on each side.
    always_comb begin
        full  = level > CW'(DEPTH - WR_UNITS);
        empty = level < CW'(RD_UNITS);
        wr_go = wr_en && !full;
        rd_go = rd_en && !empty;
    end

    // Next occupancy, with simultaneous read and write combined.
    always_comb begin
        level_nxt = level;
        if (wr_go) level_nxt = level_nxt + CW'(WR_UNITS);
        if (rd_go) level_nxt = level_nxt - CW'(RD_UNITS);
    end

    // Pointer and occupancy registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
        end else begin
            level <= level_nxt;
            if (wr_go) wptr <= wptr + AW'(WR_UNITS);
            if (rd_go) rptr <= rptr + AW'(RD_UNITS);
        end
    end

    // R5: occupancy never exceeds the capacity.
    a_r5_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CW'(DEPTH));

    // R10: a refused read and a refused write leave the count untouched.
    a_r10_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_go && !rd_go) |=> $stable(level));

endmodule

// File: rtl/asym_fifo_store.sv
// Slice storage with MSB-first lane mapping and a registered read port.
// A write places its top slice at the write pointer. A read assembles
// slices from the read pointer upward, putting the first slice in the
// top lane. Assumes the pointers are aligned to their word sizes.
module asym_fifo_store #(
    parameter int NW       = 8,
    parameter int DEPTH    = 32,
    parameter int WR_UNITS = 4,
    parameter int RD_UNITS = 1,
    localparam int AW      = $clog2(DEPTH),
    localparam int WR_W    = NW * WR_UNITS,
    localparam int RD_W    = NW * RD_UNITS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_go,
    input  logic [AW-1:0]   wptr,
    input  logic [WR_W-1:0] wr_data,
    input  logic            rd_go,
    input  logic [AW-1:0]   rptr,
    output logic [RD_W-1:0] rd_data,
    output logic            rd_valid
);

    logic [NW-1:0] mem [DEPTH];

    // Write: split the word into slices, top slice at the lowest address.
    always_ff @(posedge clk) begin
        if (wr_go) begin
            for (int k = 0; k < WR_UNITS; k++) begin
                mem[wptr + AW'(k)] <= wr_data[(WR_UNITS-1-k)*NW +: NW];
            end
        end
    end

    // Read: gather slices into the output register, and flag the cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_go;
            if (rd_go) begin
                for (int k = 0; k < RD_UNITS; k++) begin
                    rd_data[(RD_UNITS-1-k)*NW +: NW] <= mem[rptr + AW'(k)];
                end
            end
        end
    end

    // R8: a read request gives a valid word on the following cycle.
    a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        rd_go |=> rd_valid);

    // R8: without a read request, the next cycle shows no valid word.
    a_r8_valid_only: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_go |=> !rd_valid);

endmodule

// File: rtl/asym_width_fifo.sv
// Top: a single-clock FIFO whose write and read widths differ by a
// power-of-two factor up to 8. Data is held in slices of the narrower
// width. Assumes DEPTH (in slices) is a power of two and a multiple of
// the wider port's slice count.
module asym_width_fifo
    import asym_fifo_pkg::*;
#(
    parameter int WR_W  = 32,
    parameter int RD_W  = 8,
    parameter int DEPTH = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [WR_W-1:0] wr_data,
    output logic            full,
    input  logic            rd_en,
    output logic [RD_W-1:0] rd_data,
    output logic            empty,
    output logic            rd_valid
);

    localparam int NW       = slice_width(WR_W, RD_W);
    localparam int WR_UNITS = slices_per(WR_W, WR_W, RD_W);
    localparam int RD_UNITS = slices_per(RD_W, WR_W, RD_W);
    localparam int AW       = $clog2(DEPTH);

    logic          wr_go;
    logic          rd_go;
    logic [AW-1:0] wptr;
    logic [AW-1:0] rptr;

    asym_fifo_ctrl #(
        .DEPTH    (DEPTH),
        .WR_UNITS (WR_UNITS),
        .RD_UNITS (RD_UNITS)
    ) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .full  (full),
        .empty (empty),
        .wr_go (wr_go),
        .rd_go (rd_go),
        .wptr  (wptr),
        .rptr  (rptr)
    );

    asym_fifo_store #(
        .NW       (NW),
        .DEPTH    (DEPTH),
        .WR_UNITS (WR_UNITS),
        .RD_UNITS (RD_UNITS)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_go    (wr_go),
        .wptr     (wptr),
        .wr_data  (wr_data),
        .rd_go    (rd_go),
        .rptr     (rptr),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    // R4: with nothing written, an empty queue stays empty.
    a_r4_empty_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && !wr_en) |=> empty);

    // R5: with nothing read, a full queue stays full.
    a_r5_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !rd_en) |=> full);

    // R6: a read against an empty queue produces no valid word.
    a_r6_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && empty) |=> !rd_valid);

    // R7: a refused write with no read leaves the write pointer in place.
    a_r7_full_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full && !rd_en) |=> (wptr == $past(wptr)));

endmodule

// File: tb/asym_width_fifo_test.sv
`timescale 1ns/1ps
// Bench: drives a 32->8 splitting instance and an 8->32 packing
// instance against slice-level reference queues.
module asym_width_fifo_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Instance A: 32-bit writes, 8-bit reads.
    logic        wr_en_a = 1'b0, rd_en_a = 1'b0;
    logic [31:0] wr_data_a = '0;
    logic [7:0]  rd_data_a;
    logic        full_a, empty_a, valid_a;

    // Instance B: 8-bit writes, 32-bit reads.
    logic        wr_en_b = 1'b0, rd_en_b = 1'b0;
    logic [7:0]  wr_data_b = '0;
    logic [31:0] rd_data_b;
    logic        full_b, empty_b, valid_b;

    asym_width_fifo #(.WR_W(32), .RD_W(8), .DEPTH(32)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en_a), .wr_data(wr_data_a),
        .full(full_a), .rd_en(rd_en_a), .rd_data(rd_data_a),
        .empty(empty_a), .rd_valid(valid_a)
    );

    asym_width_fifo #(.WR_W(8), .RD_W(32), .DEPTH(32)) uut_pack (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en_b), .wr_data(wr_data_b),
        .full(full_b), .rd_en(rd_en_b), .rd_data(rd_data_b),
        .empty(empty_b), .rd_valid(valid_b)
    );

    // Reference state.
    logic [7:0]  qa[$];
    logic [7:0]  qb[$];
    bit          pend_a = 0, pend_b = 0;
    logic [7:0]  exp_a = '0;
    logic [31:0] exp_b = '0;
    bit ign_rd_a = 0, ign_wr_a = 0, both_a = 0;
    bit ign_rd_b = 0, ign_wr_b = 0, both_b = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // One cycle on instance A (called at a falling edge).
    task automatic cycle_a(input bit we, input logic [31:0] wd, input bit re);
        bit wacc, racc;
        chk(both_a ? "R10" : "R4", {31'b0, empty_a}, {31'b0, qa.size() < 1});
        chk(ign_wr_a ? "R7" : (both_a ? "R10" : "R5"), {31'b0, full_a}, {31'b0, qa.size() > 28});
        chk(ign_rd_a ? "R6" : "R8", {31'b0, valid_a}, {31'b0, pend_a});
        if (pend_a) chk("R2", {24'b0, rd_data_a}, {24'b0, exp_a});
        wacc = we && !(qa.size() > 28);
        racc = re && !(qa.size() < 1);
        wr_en_a = we; wr_data_a = wd; rd_en_a = re;
        @(posedge clk);
        pend_a = racc;
        if (racc) exp_a = qa.pop_front();
        if (wacc) for (int k = 0; k < 4; k++) qa.push_back(wd[(3-k)*8 +: 8]);
        ign_rd_a = re && !racc;
        ign_wr_a = we && !wacc;
        both_a = wacc && racc;
        @(negedge clk);
        wr_en_a = 1'b0; rd_en_a = 1'b0;
    endtask

    // One cycle on instance B (called at a falling edge).
    task automatic cycle_b(input bit we, input logic [7:0] wd, input bit re);
        bit wacc, racc;
        chk(both_b ? "R10" : "R4", {31'b0, empty_b}, {31'b0, qb.size() < 4});
        chk(ign_wr_b ? "R7" : (both_b ? "R10" : "R5"), {31'b0, full_b}, {31'b0, qb.size() > 31});
        chk(ign_rd_b ? "R6" : "R8", {31'b0, valid_b}, {31'b0, pend_b});
        if (pend_b) chk("R1 R3", rd_data_b, exp_b);
        wacc = we && !(qb.size() > 31);
        racc = re && !(qb.size() < 4);
        wr_en_b = we; wr_data_b = wd; rd_en_b = re;
        @(posedge clk);
        pend_b = racc;
        if (racc) for (int k = 0; k < 4; k++) exp_b[(3-k)*8 +: 8] = qb.pop_front();
        if (wacc) qb.push_back(wd);
        ign_rd_b = re && !racc;
        ign_wr_b = we && !wacc;
        both_b = wacc && racc;
        @(negedge clk);
        wr_en_b = 1'b0; rd_en_b = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R9: reset state of both instances.
        chk("R9", {31'b0, empty_a}, 32'd1);
        chk("R9", {31'b0, full_a}, 32'd0);
        chk("R9", {31'b0, valid_a}, 32'd0);
        chk("R9", {24'b0, rd_data_a}, 32'd0);
        chk("R9", {31'b0, empty_b}, 32'd1);
        chk("R9", rd_data_b, 32'd0);

        // R2/R4: one wide word, four slice reads, then one refused read (R6).
        cycle_a(1, 32'hC7A53C81, 0);
        for (int i = 0; i < 5; i++) cycle_a(0, '0, 1);
        cycle_a(0, '0, 0);
        // R5/R7: fill past capacity, then drain.
        for (int i = 0; i < 10; i++) cycle_a(1, 32'h10203040 + 32'(i) * 32'h01010101, 0);
        cycle_a(0, '0, 0);
        for (int i = 0; i < 3; i++) cycle_a(0, '0, 1);
        for (int i = 0; i < 6; i++) cycle_a(1, 32'hA0B0C0D0 ^ 32'(i), 1); // R10
        for (int i = 0; i < 40; i++) cycle_a(0, '0, 1);
        for (int i = 0; i < 3000; i++)
            cycle_a(($urandom % 100) < 35, $urandom, ($urandom % 100) < 70);
        for (int i = 0; i < 40; i++) cycle_a(0, '0, 1);
        cycle_a(0, '0, 0);

        // R3/R4: three narrow writes keep empty, read refused (R6), fourth completes.
        cycle_b(1, 8'h11, 0);
        cycle_b(1, 8'h22, 0);
        cycle_b(1, 8'h33, 1);
        cycle_b(1, 8'h44, 0);
        cycle_b(0, '0, 1);
        cycle_b(0, '0, 0);
        // R5/R7: fill past capacity, then drain.
        for (int i = 0; i < 35; i++) cycle_b(1, 8'(8'h50 + i), 0);
        cycle_b(0, '0, 0);
        for (int i = 0; i < 2; i++) cycle_b(0, '0, 1);
        for (int i = 0; i < 8; i++) cycle_b(1, 8'(8'hE0 + i), 1); // R10
        for (int i = 0; i < 12; i++) cycle_b(0, '0, 1);
        for (int i = 0; i < 3000; i++)
            cycle_b(($urandom % 100) < 70, 8'($urandom), ($urandom % 100) < 25);
        for (int i = 0; i < 12; i++) cycle_b(0, '0, 1);
        cycle_b(0, '0, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule